// File: doc/BRIEF.md
# UART Interrupt Identification Unit

This block decides which of a serial port's interrupt causes the host sees, and when the host interrupt line is driven. It watches five raw conditions: a receive line error, received data ready, a receive character timeout, an empty transmit holding register, and a modem status change. It combines them with four enable bits. From these it produces a four-bit identification code and the host interrupt. The receive and modem causes are level conditions, and they stay pending for as long as their raw input is high. The transmit-empty cause is an event, so the block holds it in its own pending flag.

The host reads the identification code with a read strobe. If that read reports transmit-empty, the read retires the transmit-empty event. A write strobe to the holding register also retires it. A read that reports any other cause leaves the transmit-empty flag untouched, so that cause comes up again once the higher causes are gone. The two transmitter status bits the host sees always follow the transmitter itself, whatever the interrupt state.

The code and the interrupt are registered. They reflect the inputs one clock after those inputs are sampled.

Top module: `uart_irq_ident`

## Requirements
- R1: When the line error input is high and its enable (bit 2) is set, the code is 0110, whatever other causes are pending.
- R2: With line error absent, the code follows this fixed order: data ready 0100 (enable bit 0), then timeout 1100 (enable bit 0), then transmit-empty 0010 (enable bit 1), then modem change 0000 (enable bit 3).
- R3: A rising edge of the transmit-empty input while enable bit 1 is set makes transmit-empty pending.
- R4: Setting enable bit 1 while the transmit-empty input is already high makes transmit-empty pending.
- R5: A holding-register write strobe clears the transmit-empty pending flag.
- R6: A read strobe clears the transmit-empty flag only while the code shown is 0010. A read while another code is shown leaves the flag set.
- R7: A transmit-empty cause that survives a read of a higher cause shows code 0010 and raises the host interrupt once the higher causes go away.
- R8: The code is 0001 and the host interrupt is low exactly when no enabled cause is pending.
- R9: A cause whose enable bit is clear does not affect the code or the interrupt.
- R10: tx_status bit 0 equals the transmit-empty input and bit 1 equals the transmitter-idle input at all times, whether or not an interrupt is pending.
- R11: The code and the host interrupt change on the clock edge after the inputs that cause the change are sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_en | input | 4 | Enables: bit0 receive data/timeout, bit1 transmit-empty, bit2 line error, bit3 modem |
| src_line_err | input | 1 | Receive line error condition (level) |
| src_rx_ready | input | 1 | Received data available (level) |
| src_rx_timeout | input | 1 | Character timeout (level) |
| src_tx_empty | input | 1 | Transmit holding register is empty |
| src_tx_idle | input | 1 | Transmitter fully idle |
| src_modem | input | 1 | Modem status change (level) |
| id_rd | input | 1 | Read strobe of the identification code |
| hold_wr | input | 1 | Write strobe of the transmit holding register |
| id_code | output | 4 | Identification code of the highest pending cause |
| host_irq | output | 1 | Host interrupt |
| tx_status | output | 2 | {transmitter idle, holding register empty} |

## Verification
The hardest case to reach from the ports is a read that lands while transmit-empty is pending but hidden behind a higher cause. The stimulus first raises the empty condition with its enable set and confirms that code 0010 appears. It then raises the line error so that 0110 is shown, and pulses the read strobe. After the line error is dropped, the bench expects 0010 to come back with the interrupt high. A second read then has to clear the flag and return the code to 0001.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int EN_W   = 4;
    localparam int SRC_N  = 5;
    localparam int CODE_W = 4;

    localparam int EN_RX = 0;
    localparam int EN_TX = 1;
    localparam int EN_LS = 2;
    localparam int EN_MS = 3;

    typedef enum logic [CODE_W-1:0] {
        ID_LINE   = 4'b0110,
        ID_RXDATA = 4'b0100,
        ID_TMO    = 4'b1100,
        ID_TXE    = 4'b0010,
        ID_MODEM  = 4'b0000,
        ID_NONE   = 4'b0001
    } id_code_e;

    typedef struct packed {
        logic empty;
        logic en;
        logic pend;
    } txe_state_t;

    typedef struct packed {
        id_code_e code;
        logic     irq;
    } id_state_t;

    function automatic id_code_e code_of(input int idx);
        case (idx)
            0:       return ID_LINE;
            1:       return ID_RXDATA;
            2:       return ID_TMO;
            3:       return ID_TXE;
            default: return ID_MODEM;
        endcase
    endfunction

endpackage

// File: rtl/uart_txe_track.sv
module uart_txe_track
    import uart_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_tx,
    input  logic tx_empty,
    input  logic hold_wr,
    input  logic rd_retire,
    output logic pend
);

    txe_state_t st_q, st_d;
    logic set_ev, clr_ev;

    always_comb begin
        st_d       = st_q;
        st_d.empty = tx_empty;
        st_d.en    = en_tx;
        set_ev     = en_tx && tx_empty && (!st_q.empty || !st_q.en);
        clr_ev     = hold_wr || rd_retire;
        if (clr_ev)
            st_d.pend = 1'b0;
        else if (set_ev)
            st_d.pend = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign pend = st_q.pend;

    AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (en_tx && $rose(tx_empty) && !hold_wr && !rd_retire) |=> pend); // R3
    AST_ENABLE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(en_tx) && tx_empty && !hold_wr && !rd_retire) |=> pend); // R4
    AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        hold_wr |=> !pend); // R5
    AST_KEEP_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !hold_wr && !rd_retire) |=> pend); // R6

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
    import uart_irq_pkg::*;
(
    input  logic [SRC_N-1:0] req,
    output id_code_e         code,
    output logic             any
);

    always_comb begin
        code = ID_NONE;
        for (int i = SRC_N - 1; i >= 0; i--) begin
            if (req[i])
                code = code_of(i);
        end
        any = |req;
    end

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [EN_W-1:0] irq_en,
    input  logic            src_line_err,
    input  logic            src_rx_ready,
    input  logic            src_rx_timeout,
    input  logic            src_tx_empty,
    input  logic            src_tx_idle,
    input  logic            src_modem,
    input  logic            id_rd,
    input  logic            hold_wr,
    output logic [CODE_W-1:0] id_code,
    output logic            host_irq,
    output logic [1:0]      tx_status
);

    id_state_t        st_q, st_d;
    logic             txe_pend;
    logic             rd_retire;
    logic [SRC_N-1:0] req;
    id_code_e         win_code;
    logic             win_any;

    assign rd_retire = id_rd && (st_q.code == ID_TXE);

    uart_txe_track u_txe (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_tx     (irq_en[EN_TX]),
        .tx_empty  (src_tx_empty),
        .hold_wr   (hold_wr),
        .rd_retire (rd_retire),
        .pend      (txe_pend)
    );

    always_comb begin
        req[0] = src_line_err   && irq_en[EN_LS];
        req[1] = src_rx_ready   && irq_en[EN_RX];
        req[2] = src_rx_timeout && irq_en[EN_RX];
        req[3] = txe_pend       && irq_en[EN_TX];
        req[4] = src_modem      && irq_en[EN_MS];
    end

    uart_irq_prio u_prio (
        .req  (req),
        .code (win_code),
        .any  (win_any)
    );

    always_comb begin
        st_d      = st_q;
        st_d.code = win_code;
        st_d.irq  = win_any;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.code <= ID_NONE;
            st_q.irq  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign id_code   = st_q.code;
    assign host_irq  = st_q.irq;
    assign tx_status = {src_tx_idle, src_tx_empty};

    AST_LINE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (src_line_err && irq_en[EN_LS]) |=> (id_code == 4'b0110)); // R1
    AST_NONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (host_irq == (id_code != 4'b0001))); // R8
    AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(src_line_err || src_rx_ready || src_rx_timeout || src_modem || txe_pend)
        |=> !host_irq); // R9
    AST_TXE_SURFACES: assert property (@(posedge clk) disable iff (!rst_n)
        (txe_pend && irq_en[EN_TX] && !(src_line_err && irq_en[EN_LS])
         && !((src_rx_ready || src_rx_timeout) && irq_en[EN_RX]))
        |=> (id_code == 4'b0010) && host_irq); // R7

endmodule

// File: tb/uart_irq_ident_bench.sv
module uart_irq_ident_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] irq_en;
    logic       src_line_err, src_rx_ready, src_rx_timeout;
    logic       src_tx_empty, src_tx_idle, src_modem;
    logic       id_rd, hold_wr;
    logic [3:0] id_code;
    logic       host_irq;
    logic [1:0] tx_status;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    uart_irq_ident u_uart_irq_ident (
        .clk            (clk),
        .rst_n          (rst_n),
        .irq_en         (irq_en),
        .src_line_err   (src_line_err),
        .src_rx_ready   (src_rx_ready),
        .src_rx_timeout (src_rx_timeout),
        .src_tx_empty   (src_tx_empty),
        .src_tx_idle    (src_tx_idle),
        .src_modem      (src_modem),
        .id_rd          (id_rd),
        .hold_wr        (hold_wr),
        .id_code        (id_code),
        .host_irq       (host_irq),
        .tx_status      (tx_status)
    );

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic chk(input string req, input logic [3:0] exp_code, input logic exp_irq);
        checks++;
        if (id_code !== exp_code || host_irq !== exp_irq) begin
            errors++;
            $display("FAIL %s: code=%b irq=%b expected code=%b irq=%b",
                     req, id_code, host_irq, exp_code, exp_irq);
        end
    endtask

    task automatic clear_inputs();
        irq_en = 4'b0000;
        src_line_err = 0; src_rx_ready = 0; src_rx_timeout = 0;
        src_tx_empty = 0; src_tx_idle = 0; src_modem = 0;
        id_rd = 0; hold_wr = 0;
    endtask

    task automatic read_pulse();
        id_rd = 1'b1;
        step(1);
        id_rd = 1'b0;
    endtask

    task automatic t_reset();
        clear_inputs();
        rst_n = 1'b0;
        step(3);
        chk("R8 reset", 4'b0001, 1'b0);
        rst_n = 1'b1;
        step(1);
    endtask

    task automatic t_priority();
        irq_en = 4'b1101;
        src_line_err = 1; src_rx_ready = 1; src_rx_timeout = 1; src_modem = 1;
        step(1);
        chk("R1 line error over all", 4'b0110, 1'b1);
        src_line_err = 0; step(1);
        chk("R2 data ready", 4'b0100, 1'b1);
        src_rx_ready = 0; step(1);
        chk("R2 timeout", 4'b1100, 1'b1);
        src_rx_timeout = 0; step(1);
        chk("R2 modem", 4'b0000, 1'b1);
        src_modem = 0; step(1);
        chk("R8 none pending", 4'b0001, 1'b0);
    endtask

    task automatic t_latency();
        irq_en = 4'b0100;
        src_line_err = 1;
        #1;
        chk("R11 not before edge", 4'b0001, 1'b0);
        step(1);
        chk("R11 after one edge", 4'b0110, 1'b1);
        src_line_err = 0;
        step(1);
        chk("R11 release", 4'b0001, 1'b0);
    endtask

    task automatic t_disabled();
        irq_en = 4'b0000;
        src_line_err = 1; src_rx_ready = 1; src_modem = 1; src_tx_empty = 1;
        step(3);
        chk("R9 all disabled", 4'b0001, 1'b0);
        irq_en = 4'b1000;
        step(1);
        chk("R9 only modem enabled", 4'b0000, 1'b1);
        src_line_err = 0; src_rx_ready = 0; src_modem = 0; irq_en = 4'b0000;
        hold_wr = 1; src_tx_empty = 0; step(1); hold_wr = 0;
        step(2);
    endtask

    task automatic t_txe_edge();
        irq_en = 4'b0010;
        src_tx_empty = 1;
        step(2);
        chk("R3 rising empty", 4'b0010, 1'b1);
        hold_wr = 1; src_tx_empty = 0;
        step(1);
        hold_wr = 0;
        step(1);
        chk("R5 write clears", 4'b0001, 1'b0);
    endtask

    task automatic t_txe_enable();
        irq_en = 4'b0000;
        src_tx_empty = 1;
        step(3);
        chk("R9 empty but disabled", 4'b0001, 1'b0);
        irq_en = 4'b0010;
        step(2);
        chk("R4 enable while empty", 4'b0010, 1'b1);
        read_pulse();
        step(1);
        chk("R6 read of 0010 clears", 4'b0001, 1'b0);
        step(2);
        chk("R6 stays cleared with empty high", 4'b0001, 1'b0);
    endtask

    task automatic t_hidden_read();
        irq_en = 4'b0110;
        src_tx_empty = 0; step(1);
        src_tx_empty = 1; step(2);
        chk("R3 pending before hide", 4'b0010, 1'b1);
        src_line_err = 1; step(1);
        chk("R1 hides transmit-empty", 4'b0110, 1'b1);
        read_pulse();
        read_pulse();
        step(1);
        chk("R6 other read keeps", 4'b0110, 1'b1);
        src_line_err = 0; step(1);
        chk("R7 resurfaces", 4'b0010, 1'b1);
        read_pulse();
        step(1);
        chk("R6 final read clears", 4'b0001, 1'b0);
    endtask

    task automatic t_status();
        irq_en = 4'b0110;
        src_line_err = 1; src_tx_idle = 1; src_tx_empty = 1;
        #1;
        checks++;
        if (tx_status !== 2'b11) begin
            errors++;
            $display("FAIL R10: tx_status=%b expected 11", tx_status);
        end
        src_tx_idle = 0; src_tx_empty = 0;
        #1;
        checks++;
        if (tx_status !== 2'b00) begin
            errors++;
            $display("FAIL R10: tx_status=%b expected 00", tx_status);
        end
        src_tx_empty = 1;
        #1;
        checks++;
        if (tx_status !== 2'b01) begin
            errors++;
            $display("FAIL R10: tx_status=%b expected 01", tx_status);
        end
        src_line_err = 0;
        step(1);
    endtask

    initial begin
        rst_n = 1'b0;
        clear_inputs();
        @(negedge clk);
        t_reset();
        t_priority();
        t_latency();
        t_disabled();
        t_txe_edge();
        t_txe_enable();
        clear_inputs(); step(2);
        t_hidden_read();
        t_status();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule